// File: doc/BRIEF.md
# Debug Breakpoint Unit

This block sits beside a processor core and watches three kinds of activity: the address of each instruction fetch, the retirement of each instruction (with a flag telling whether it left the sequential path), and every data memory read or write. When a watched condition occurs, the block sends a one-cycle break request to the debug controller. It also records which condition fired in a sticky status code that the debugger reads back and later clears.

Four address comparator slots are shared among roles according to a 3-bit mode. The roles are exact program-address match, exact data-address match, and a masked match. In a masked match, one slot holds the reference value and its neighbour holds the mask. A break on any non-sequential instruction and a single-step break can be enabled in addition to the slots. The debugger programs everything through a small write port. The reset input is expected to be asserted asynchronously and released synchronously to `clk` by the reset logic of the surrounding domain.

Top module: `brk_unit`

## Requirements
- R1: After reset, `brk` is 0, `brk_code` is 0, all slot enables are 0, stepping is off and the flow-change break is off, so no input activity causes a break.
- R2: When the flow-change enable (control bit 8) is set, a cycle with `retire` and `flow_chg` both high produces `brk` high on the next cycle with code 1.
- R3: When stepping (control bit 7) is set, every cycle with `retire` high produces `brk` high on the next cycle with code 2.
- R4: A slot k acting as a program-address comparator, with its enable (control bit 3+k) set, produces `brk` on the cycle after a cycle where `fetch_vld` is high and `fetch_addr` equals the slot value. The code is 3+k.
- R5: Control bits 2:0 select the mode. Mode 0 makes slots 0 to 3 program comparators. Mode 1 makes slots 0 to 2 program comparators and slot 3 a data comparator. Mode 2 makes slots 0 and 1 program comparators and slots 2 and 3 data comparators. A slot never matches on the address kind that its role does not watch.
- R6: A data comparator matches `dmem_addr` only on an access of an enabled kind. For slot 2, bit 9 enables reads and bit 10 enables writes. For slot 3, bit 11 enables reads and bit 12 enables writes.
- R7: Mode 3 makes slots 0 and 1 exact program comparators and slot 2 a masked program comparator that uses the value of slot 3 as its mask. The masked comparator matches when ((address XOR value) AND mask) is zero, so mask bits equal to 1 are compared. Slot 3 never fires by itself.
- R8: Mode 4 works like mode 3, except that the masked slot 2 compares data addresses. The read and write enables of slot 2 apply to it.
- R9: Modes 5, 6 and 7 disable all four comparator slots. The flow-change and step breaks still work.
- R10: When several sources fire in the same cycle, the reported code is the lowest one: flow change 1, step 2, then slots 0 to 3 as codes 3 to 6.
- R11: A nonzero `brk_code` holds until a control write with bit 13 set clears it. Later breaks still pulse `brk` but do not change a held code. A source firing in the same cycle as the clear loads its own code.
- R12: A write with `cfg_sel` 0 to 3 loads the value of that slot. A write with `cfg_sel` 4 loads control bits 12:0. Writes with selector values 5 to 7 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assertion |
| fetch_vld | input | 1 | Fetch address is valid this cycle |
| fetch_addr | input | AW | Address of the instruction being fetched |
| retire | input | 1 | One instruction completed this cycle |
| flow_chg | input | 1 | The retiring instruction changed program flow |
| dmem_addr | input | AW | Data memory access address |
| dmem_rd | input | 1 | Data memory read strobe |
| dmem_wr | input | 1 | Data memory write strobe |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration register selector |
| cfg_wdata | input | AW | Configuration write data |
| brk | output | 1 | Registered one-cycle break request |
| brk_code | output | 3 | Sticky code of the source that fired |

## Verification
The bench builds the block with its default 16-bit address width. At this width, control bits 0 to 13 all fit in one configuration word, and a 16-bit mask can split an address into a compared upper byte and an ignored lower byte. Random addresses are mostly drawn from the programmed slot values, so exact and masked hits occur often in every mode, including the reserved modes 5 to 7. Directed cases set up simultaneous sources, writes to data slots whose access kind is disabled, and a clear that coincides with a new hit.

// File: rtl/brk_pkg.sv
package brk_pkg;

  localparam int NSLOT  = 4;
  localparam int CODE_W = 3;
  localparam int CTL_W  = 13;

  // control word bit positions
  localparam int CB_STEP = 7;
  localparam int CB_FLOW = 8;
  localparam int CB_CLR  = 13;

  typedef enum logic [2:0] {
    ROLE_OFF,
    ROLE_PC,
    ROLE_PC_MSK,
    ROLE_DAT,
    ROLE_DAT_MSK,
    ROLE_MASK
  } role_e;

  function automatic role_e slot_role(input logic [2:0] mode, input int k);
    role_e r;
    case (mode)
      3'd0:    r = ROLE_PC;
      3'd1:    r = (k < 3) ? ROLE_PC : ROLE_DAT;
      3'd2:    r = (k < 2) ? ROLE_PC : ROLE_DAT;
      3'd3:    r = (k < 2) ? ROLE_PC : ((k == 2) ? ROLE_PC_MSK : ROLE_MASK);
      3'd4:    r = (k < 2) ? ROLE_PC : ((k == 2) ? ROLE_DAT_MSK : ROLE_MASK);
      default: r = ROLE_OFF;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/brk_cfg.sv
module brk_cfg
  import brk_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      we,
  input  logic [2:0]                sel,
  input  logic [AW-1:0]             wdata,
  output logic [NSLOT-1:0][AW-1:0]  val,
  output logic [2:0]                mode,
  output logic [NSLOT-1:0]          slot_en,
  output logic                      step_en,
  output logic                      flow_en,
  output logic [NSLOT-1:0]          rd_en,
  output logic [NSLOT-1:0]          wr_en,
  output logic                      clr
);

  logic [NSLOT-1:0][AW-1:0] val_q, val_d;
  logic [CTL_W-1:0]         ctl_q, ctl_d;
  logic                     val_wr, ctl_wr;

  assign val_wr = we && (sel[2] == 1'b0);
  assign ctl_wr = we && (sel == 3'd4);

  always_comb begin
    val_d = val_q;
    ctl_d = ctl_q;
    if (val_wr) val_d[sel[1:0]] = wdata;
    if (ctl_wr) ctl_d = wdata[CTL_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= '0;
      ctl_q <= '0;
    end else begin
      if (val_wr) val_q <= val_d;
      if (ctl_wr) ctl_q <= ctl_d;
    end
  end

  assign val     = val_q;
  assign mode    = ctl_q[2:0];
  assign slot_en = ctl_q[3 +: NSLOT];
  assign step_en = ctl_q[CB_STEP];
  assign flow_en = ctl_q[CB_FLOW];
  assign rd_en   = {ctl_q[11], ctl_q[9], 2'b00};
  assign wr_en   = {ctl_q[12], ctl_q[10], 2'b00};
  assign clr     = ctl_wr && wdata[CB_CLR];

endmodule

// File: rtl/brk_cmp.sv
module brk_cmp
  import brk_pkg::*;
#(
  parameter int AW = 16
) (
  input  role_e         role,
  input  logic          en,
  input  logic          rd_en,
  input  logic          wr_en,
  input  logic [AW-1:0] val,
  input  logic [AW-1:0] msk,
  input  logic          fetch_vld,
  input  logic [AW-1:0] fetch_addr,
  input  logic [AW-1:0] d_addr,
  input  logic          d_rd,
  input  logic          d_wr,
  output logic          hit
);

  logic          is_pc, is_dat, masked, eq, acc_ok;
  logic [AW-1:0] cmp_msk, addr;

  assign is_pc   = (role == ROLE_PC)  || (role == ROLE_PC_MSK);
  assign is_dat  = (role == ROLE_DAT) || (role == ROLE_DAT_MSK);
  assign masked  = (role == ROLE_PC_MSK) || (role == ROLE_DAT_MSK);
  assign cmp_msk = masked ? msk : '1;
  assign addr    = is_pc ? fetch_addr : d_addr;
  assign eq      = ((addr ^ val) & cmp_msk) == '0;
  assign acc_ok  = is_pc ? fetch_vld : ((d_rd && rd_en) || (d_wr && wr_en));
  assign hit     = en && (is_pc || is_dat) && acc_ok && eq;

endmodule

// File: rtl/brk_prio.sv
module brk_prio
  import brk_pkg::*;
(
  input  logic              flow_hit,
  input  logic              step_hit,
  input  logic [NSLOT-1:0]  slot_hit,
  output logic [CODE_W-1:0] code,
  output logic              any
);

  always_comb begin
    code = '0;
    for (int k = NSLOT - 1; k >= 0; k--) begin
      if (slot_hit[k]) code = CODE_W'(k + 3);
    end
    if (step_hit) code = CODE_W'(2);
    if (flow_hit) code = CODE_W'(1);
  end

  assign any = flow_hit || step_hit || (|slot_hit);

endmodule

// File: rtl/brk_unit.sv
module brk_unit
  import brk_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_vld,
  input  logic [AW-1:0]     fetch_addr,
  input  logic              retire,
  input  logic              flow_chg,
  input  logic [AW-1:0]     dmem_addr,
  input  logic              dmem_rd,
  input  logic              dmem_wr,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_sel,
  input  logic [AW-1:0]     cfg_wdata,
  output logic              brk,
  output logic [CODE_W-1:0] brk_code
);

  logic [NSLOT-1:0][AW-1:0] cfg_val;
  logic [2:0]               cfg_mode;
  logic [NSLOT-1:0]         cfg_en, cfg_rd, cfg_wr;
  logic                     cfg_step, cfg_flow, cfg_clr;
  logic [NSLOT-1:0]         slot_hit;
  logic                     flow_hit, step_hit, any_hit;
  logic [CODE_W-1:0]        hit_code;
  logic [CODE_W-1:0]        st_q, st_d, st_base;
  logic                     brk_q;

  brk_cfg #(.AW(AW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .val(cfg_val), .mode(cfg_mode), .slot_en(cfg_en), .step_en(cfg_step),
    .flow_en(cfg_flow), .rd_en(cfg_rd), .wr_en(cfg_wr), .clr(cfg_clr)
  );

  for (genvar k = 0; k < NSLOT; k++) begin : g_slot
    brk_cmp #(.AW(AW)) u_cmp (
      .role(slot_role(cfg_mode, k)), .en(cfg_en[k]),
      .rd_en(cfg_rd[k]), .wr_en(cfg_wr[k]),
      .val(cfg_val[k]), .msk(cfg_val[NSLOT-1]),
      .fetch_vld(fetch_vld), .fetch_addr(fetch_addr),
      .d_addr(dmem_addr), .d_rd(dmem_rd), .d_wr(dmem_wr),
      .hit(slot_hit[k])
    );
  end

  assign flow_hit = retire && flow_chg && cfg_flow;
  assign step_hit = retire && cfg_step;

  brk_prio u_prio (
    .flow_hit(flow_hit), .step_hit(step_hit), .slot_hit(slot_hit),
    .code(hit_code), .any(any_hit)
  );

  always_comb begin
    st_base = cfg_clr ? '0 : st_q;
    st_d    = (st_base == '0 && any_hit) ? hit_code : st_base;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= '0;
      brk_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      brk_q <= any_hit;
    end
  end

  assign brk      = brk_q;
  assign brk_code = st_q;

endmodule

// File: rtl/brk_chk.sv
module brk_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fetch_vld,
  input logic          retire,
  input logic          flow_chg,
  input logic          dmem_rd,
  input logic          dmem_wr,
  input logic          cfg_we,
  input logic [2:0]    cfg_sel,
  input logic [AW-1:0] cfg_wdata,
  input logic [2:0]    cfg_mode,
  input logic          cfg_step,
  input logic          cfg_flow,
  input logic          brk,
  input logic [2:0]    brk_code
);

  logic clr_wr;
  assign clr_wr = cfg_we && (cfg_sel == 3'd4) && cfg_wdata[13];

  // R2
  flow_brk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (retire && flow_chg && cfg_flow) |=> brk);

  // R9
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode >= 3'd5 && !cfg_flow && !cfg_step) |=> !brk);

  // R11
  code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_code != 3'd0 && !clr_wr) |=> $stable(brk_code));

  // R11
  code_load_brk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_code != 3'd0 && $past(brk_code) == 3'd0) |-> brk);

  // R10
  code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk_code <= 3'd6);

  // R4
  brk_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk |-> $past(fetch_vld || retire || dmem_rd || dmem_wr));

endmodule

bind brk_unit brk_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .fetch_vld(fetch_vld), .retire(retire),
  .flow_chg(flow_chg), .dmem_rd(dmem_rd), .dmem_wr(dmem_wr),
  .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
  .cfg_mode(cfg_mode), .cfg_step(cfg_step), .cfg_flow(cfg_flow),
  .brk(brk), .brk_code(brk_code)
);

// File: tb/test_brk_unit.sv
`timescale 1ns/1ps
module test_brk_unit;

  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          fetch_vld, retire, flow_chg, dmem_rd, dmem_wr, cfg_we;
  logic [AW-1:0] fetch_addr, dmem_addr, cfg_wdata;
  logic [2:0]    cfg_sel;
  logic          brk;
  logic [2:0]    brk_code;

  int n_chk = 0;
  int n_bad = 0;

  brk_unit #(.AW(AW)) i_brk_unit (
    .clk(clk), .rst_n(rst_n), .fetch_vld(fetch_vld), .fetch_addr(fetch_addr),
    .retire(retire), .flow_chg(flow_chg), .dmem_addr(dmem_addr),
    .dmem_rd(dmem_rd), .dmem_wr(dmem_wr), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .brk(brk), .brk_code(brk_code)
  );

  always #10 clk = ~clk;

  // bench model of the programmed state (R12 register layout)
  logic [AW-1:0] m_val [4];
  logic [2:0]    m_mode;
  logic [3:0]    m_en;
  logic          m_step, m_flow;
  logic [3:0]    m_rd, m_wr;
  logic [2:0]    m_stat;
  logic          exp_brk;

  // roles: 0 off, 1 exact pc, 2 masked pc, 3 exact data, 4 masked data, 5 mask holder
  function automatic int role_b(input logic [2:0] md, input int k);
    if (md == 0) return 1;
    if (md == 1) return (k == 3) ? 3 : 1;
    if (md == 2) return (k >= 2) ? 3 : 1;
    if (md == 3 || md == 4) begin
      if (k < 2) return 1;
      if (k == 3) return 5;
      return (md == 3) ? 2 : 4;
    end
    return 0;
  endfunction

  function automatic logic [2:0] model_code(input logic fv, input logic [AW-1:0] fa,
      input logic rt, input logic fc, input logic [AW-1:0] da, input logic dr, input logic dw);
    if (rt && fc && m_flow) return 3'd1;
    if (rt && m_step) return 3'd2;
    for (int k = 0; k < 4; k++) begin
      int r;
      logic [AW-1:0] mk;
      r  = role_b(m_mode, k);
      mk = (r == 2 || r == 4) ? m_val[3] : {AW{1'b1}};
      if (m_en[k]) begin
        if ((r == 1 || r == 2) && fv && (((fa ^ m_val[k]) & mk) == 0)) return 3'(k + 3);
        if ((r == 3 || r == 4) && ((dr && m_rd[k]) || (dw && m_wr[k]))
            && (((da ^ m_val[k]) & mk) == 0)) return 3'(k + 3);
      end
    end
    return 3'd0;
  endfunction

  function automatic string auto_tag(input logic [2:0] c);
    int r;
    if (c == 1) return "R2";
    if (c == 2) return "R3";
    if (c == 0) return (m_mode >= 5) ? "R9" : "R5";
    r = role_b(m_mode, int'(c) - 3);
    if (r == 2) return "R7";
    if (r == 4) return "R8";
    if (r == 3) return "R6";
    return "R4";
  endfunction

  function automatic logic [AW-1:0] ctl(input logic [2:0] md, input logic [3:0] en,
      input logic st, input logic fl, input logic r2, input logic w2,
      input logic r3, input logic w3, input logic cl);
    return AW'({cl, w3, r3, w2, r2, fl, st, en, md});
  endfunction

  task automatic check(input string tag, input string what, input logic [7:0] act,
      input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // one cycle: drive at negedge, model, then check at following negedge
  task automatic cyc(input logic fv, input logic [AW-1:0] fa, input logic rt,
      input logic fc, input logic [AW-1:0] da, input logic dr, input logic dw,
      input logic we, input logic [2:0] sel, input logic [AW-1:0] wd, input string tag);
    logic [2:0] c, st;
    string t;
    fetch_vld = fv; fetch_addr = fa; retire = rt; flow_chg = fc;
    dmem_addr = da; dmem_rd = dr; dmem_wr = dw;
    cfg_we = we; cfg_sel = sel; cfg_wdata = wd;
    c = model_code(fv, fa, rt, fc, da, dr, dw);
    t = (tag == "") ? auto_tag(c) : tag;
    st = (we && sel == 4 && wd[13]) ? 3'd0 : m_stat;
    if (st == 0 && c != 0) st = c;
    m_stat  = st;
    exp_brk = (c != 0);
    if (we && sel < 4) m_val[sel[1:0]] = wd;
    if (we && sel == 4) begin
      m_mode = wd[2:0]; m_en = wd[6:3]; m_step = wd[7]; m_flow = wd[8];
      m_rd = {wd[11], wd[9], 2'b00}; m_wr = {wd[12], wd[10], 2'b00};
    end
    @(negedge clk);
    check(t, "brk", 8'(brk), 8'(exp_brk));
    check(t, "code", 8'(brk_code), 8'(m_stat));
  endtask

  task automatic wr(input logic [2:0] sel, input logic [AW-1:0] wd, input string tag);
    cyc(0, 0, 0, 0, 0, 0, 0, 1, sel, wd, tag);
  endtask

  task automatic idle(input string tag);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int k = 0; k < 4; k++) m_val[k] = '0;
    m_mode = 0; m_en = 0; m_step = 0; m_flow = 0; m_rd = 0; m_wr = 0; m_stat = 0;
    rst_n = 1'b0;
    fetch_vld = 0; fetch_addr = 0; retire = 0; flow_chg = 0;
    dmem_addr = 0; dmem_rd = 0; dmem_wr = 0; cfg_we = 0; cfg_sel = 0; cfg_wdata = 0;
    repeat (3) @(negedge clk);
    check("R1", "brk", 8'(brk), 8'h0);
    check("R1", "code", 8'(brk_code), 8'h0);
    rst_n = 1'b1;
    // R1: everything disabled, activity at the reset slot value 0 is ignored
    cyc(1, 0, 1, 1, 0, 1, 1, 0, 0, 0, "R1");
    cyc(1, 0, 1, 0, 0, 1, 1, 0, 0, 0, "R1");

    // R12 / R4: exact program match on slot 1
    wr(1, 16'h1234, "R12");
    wr(4, ctl(0, 4'b0010, 0, 0, 0, 0, 0, 0, 0), "R12");
    cyc(1, 16'h1235, 0, 0, 0, 0, 0, 0, 0, 0, "R4");
    cyc(1, 16'h1234, 0, 0, 0, 0, 0, 0, 0, 0, "R4");
    idle("R11");
    // R12: selector 5 write has no effect
    wr(5, 16'h0000, "R12");
    cyc(1, 16'h1234, 0, 0, 0, 0, 0, 0, 0, 0, "R12");
    wr(4, ctl(0, 4'b0010, 0, 0, 0, 0, 0, 0, 1), "R11");

    // R5 / R6: mode 1, slot 3 watches data reads only
    wr(3, 16'h0040, "R12");
    wr(4, ctl(1, 4'b1000, 0, 0, 0, 0, 1, 0, 0), "R5");
    cyc(1, 16'h0040, 0, 0, 0, 0, 0, 0, 0, 0, "R5");
    cyc(0, 0, 0, 0, 16'h0040, 0, 1, 0, 0, 0, "R6");
    cyc(0, 0, 0, 0, 16'h0040, 1, 0, 0, 0, 0, "R6");
    wr(4, ctl(2, 4'b1100, 0, 0, 0, 1, 0, 0, 1), "R11");
    // R6: mode 2, slot 2 writes only
    wr(2, 16'h0080, "R12");
    cyc(0, 0, 0, 0, 16'h0080, 1, 0, 0, 0, 0, "R6");
    cyc(0, 0, 0, 0, 16'h0080, 0, 1, 0, 0, 0, "R6");
    wr(4, ctl(3, 4'b0100, 0, 0, 0, 0, 0, 0, 1), "R11");

    // R7: masked program range, upper byte compared
    wr(2, 16'h1200, "R7");
    wr(3, 16'hFF00, "R7");
    cyc(1, 16'h13AB, 0, 0, 0, 0, 0, 0, 0, 0, "R7");
    cyc(1, 16'h12AB, 0, 0, 0, 0, 0, 0, 0, 0, "R7");
    wr(4, ctl(4, 4'b1100, 0, 0, 1, 0, 1, 1, 1), "R11");
    // R8: masked data range, slot 3 must not fire alone
    cyc(0, 0, 0, 0, 16'hFF00, 1, 1, 0, 0, 0, "R8");
    cyc(0, 0, 0, 0, 16'h12FF, 0, 1, 0, 0, 0, "R8");
    cyc(0, 0, 0, 0, 16'h12FF, 1, 0, 0, 0, 0, "R8");
    wr(4, ctl(5, 4'b1111, 0, 0, 1, 1, 1, 1, 1), "R11");

    // R9: reserved mode disables slots
    cyc(1, 16'h1234, 0, 0, 16'h1200, 1, 1, 0, 0, 0, "R9");
    cyc(1, 16'hFF00, 0, 0, 16'hFF00, 1, 1, 0, 0, 0, "R9");

    // R3: stepping
    wr(4, ctl(0, 4'b0000, 1, 0, 0, 0, 0, 0, 0), "R3");
    cyc(0, 0, 1, 0, 0, 0, 0, 0, 0, 0, "R3");
    // R10: flow, step and slot together report code 1
    wr(4, ctl(0, 4'b0010, 1, 1, 0, 0, 0, 0, 1), "R10");
    cyc(1, 16'h1234, 1, 1, 0, 0, 0, 0, 0, 0, "R10");
    // R11: held code survives later breaks
    cyc(1, 16'h1234, 0, 0, 0, 0, 0, 0, 0, 0, "R11");
    // R11: clear coinciding with a slot hit loads the new code
    fetch_addr = 16'h1234;
    cyc(1, 16'h1234, 0, 0, 0, 0, 0, 1, 4, ctl(0, 4'b0010, 1, 1, 0, 0, 0, 0, 1), "R11");
    // R2: flow change without step
    wr(4, ctl(0, 4'b0000, 0, 1, 0, 0, 0, 0, 1), "R2");
    cyc(0, 0, 1, 0, 0, 0, 0, 0, 0, 0, "R2");
    cyc(0, 0, 1, 1, 0, 0, 0, 0, 0, 0, "R2");

    // random phase
    for (int i = 0; i < 6000; i++) begin
      logic we;
      logic [2:0] sel;
      logic [AW-1:0] wd, fa, da;
      we  = ($urandom % 8) == 0;
      sel = 3'($urandom % 6);
      wd  = AW'($urandom);
      if (sel == 4) wd[13] = (($urandom % 3) == 0);
      fa  = ($urandom % 2) ? (m_val[$urandom % 4] ^ AW'($urandom % 4 == 0 ? $urandom % 256 : 0))
                           : AW'($urandom);
      da  = ($urandom % 2) ? (m_val[$urandom % 4] ^ AW'($urandom % 4 == 0 ? $urandom % 256 : 0))
                           : AW'($urandom);
      cyc(1'($urandom), fa, 1'($urandom % 4 == 0), 1'($urandom), da,
          1'($urandom % 3 == 0), 1'($urandom % 3 == 0), we, sel, wd, "");
    end

    summary();
    $finish;
  end

endmodule